// File: doc/BRIEF.md
# Single-wire bus byte and command sequencer

This block drives a bit-slot engine for a single-wire bus and turns one start request into a complete transfer. A command transfer opens with a bus reset. It then sends one of two ROM commands. If a device identifier is supplied, it sends the select-one code followed by the identifier bytes. If not, it sends the address-all code. The transfer ends with the function command byte. The block also runs a lone byte write, and a lone byte read, which goes out as a write of all ones.

Each byte is exchanged full duplex. The bit in position 0 goes out first. After every slot the byte moves one place toward bit 0, and the bit the engine sampled enters at the top. After the eighth slot the register holds the received byte. When the parasite-power option is set for a command transfer, the eighth slot of the function command byte carries a strong-pullup request. The pullup output then stays on until software releases it.

A bus reset that sees no presence pulse is reported on a status output. The command sequence continues regardless.

Top module: `owseq_top`

## Requirements
- R1: After reset, busy, done, spu_on, presence_err and slot_req are all 0.
- R2: Every byte uses exactly eight bit slots. Slot k (k = 0..7) of a byte carries bit k of that byte on slot_bit, with slot_rst = 0.
- R3: The bit returned in slot k of the final byte of a transfer appears at rx_byte[k] when done is high.
- R4: op = 2'b1x (read) sends the byte 0xFF. op = 2'b01 (write) sends tx_byte. Neither uses a reset slot or a ROM command.
- R5: op = 2'b00 with use_id = 1 issues one reset slot (slot_rst = 1). It then sends 0x55, then the bytes of dev_id starting with dev_id[7:0], then cmd_byte.
- R6: op = 2'b00 with use_id = 0 issues one reset slot, then 0xCC, then cmd_byte.
- R7: slot_spu is 1 only on the eighth slot of the function command byte of a command transfer started with spu_opt = 1. It is 0 on every other slot.
- R8: spu_on rises together with done on the cycle after that slot is acknowledged. It then stays high until spu_release is sampled high, and falls on the next cycle.
- R9: presence_err takes the value of slot_nopres from the acknowledged reset slot. The transfer still completes all of its bytes.
- R10: done is a one-cycle pulse on the cycle after the final slot is acknowledged. busy is high from the cycle after start is accepted until that cycle.
- R11: A start pulse while busy is ignored. Changing op, cmd_byte, tx_byte or dev_id during a transfer does not change the bytes sent.
- R12: While slot_req is high and slot_ack is low, slot_req, slot_rst, slot_bit and slot_spu keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| op | input | 2 | 00 command transfer, 01 byte write, 1x byte read |
| use_id | input | 1 | Command transfer selects one device by identifier |
| spu_opt | input | 1 | Request strong pullup after the function command |
| cmd_byte | input | 8 | Function command byte |
| tx_byte | input | 8 | Byte for a write operation |
| dev_id | input | 64 | Device identifier, byte 0 in bits 7:0 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Byte received in the final byte slots |
| presence_err | output | 1 | Last reset saw no presence pulse |
| slot_req | output | 1 | Slot request to the bit engine |
| slot_rst | output | 1 | Requested slot is a bus reset |
| slot_bit | output | 1 | Bit to write in the requested slot |
| slot_spu | output | 1 | Enable strong pullup at the end of this slot |
| slot_ack | input | 1 | Bit engine finished the requested slot |
| slot_rbit | input | 1 | Bit sampled in the finished slot |
| slot_nopres | input | 1 | Finished reset slot saw no presence pulse |
| spu_on | output | 1 | Strong pullup active |
| spu_release | input | 1 | Turn the strong pullup off |

## Verification
The assertions take several things for granted about the bit engine. It raises slot_ack for one cycle at a time, only while slot_req is high, and never on the cycle right after a previous acknowledge. They also assume that start is not held across the cycle that accepts it. The bench's engine model waits for a request at the falling edge and acknowledges after one to three cycles. It always drops slot_ack the next cycle, and start is driven as a single-cycle pulse, so the stimulus never leaves those assumptions. Returned bits are random but open-drain consistent: a written 0 always reads back as 0.

// File: rtl/owseq_pkg.sv
package owseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RST  = 3'd1,
      ST_ROM  = 3'd2,
      ST_ID   = 3'd3,
      ST_FUNC = 3'd4,
      ST_XFER = 3'd5
   } seq_state_e;

   localparam logic [1:0] OP_CMD   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;

   function automatic logic op_is_read(input logic [1:0] op);
      return op[1];
   endfunction

endpackage

// File: rtl/owseq_shift.sv
module owseq_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic         rbit,
   output logic         tx_bit,
   output logic         last,
   output logic [W-1:0] next_val
);
   localparam int CW = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

   logic [W-1:0]  sh_q;
   logic [CW-1:0] cnt_q;

   generate
      if (W < 2) begin : g_bad_width
         $error("owseq_shift: W must be at least 2");
      end
   endgenerate

   assign tx_bit   = sh_q[0];
   assign last     = (cnt_q == LAST_IDX);
   assign next_val = {rbit, sh_q[W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         sh_q  <= load_val;
         cnt_q <= '0;
      end else if (step) begin
         sh_q  <= next_val;
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
   end

   // R2: a step taken on the last bit without a reload returns to bit 0
   p_cnt_wraps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/owseq_ctrl.sv
module owseq_ctrl
   import owseq_pkg::*;
#(
   parameter int          W        = 8,
   parameter int          ID_BYTES = 8,
   parameter logic [W-1:0] CODE_SEL = 8'h55,
   parameter logic [W-1:0] CODE_ALL = 8'hCC
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [1:0]            op,
   input  logic                  use_id,
   input  logic                  spu_opt,
   input  logic [W-1:0]          cmd_byte,
   input  logic [W-1:0]          tx_byte,
   input  logic [ID_BYTES*W-1:0] dev_id,
   input  logic                  slot_ack,
   input  logic                  slot_nopres,
   input  logic                  sh_last,
   input  logic [W-1:0]          sh_next,
   input  logic                  sh_bit,
   output logic                  sh_load,
   output logic [W-1:0]          sh_load_val,
   output logic                  sh_step,
   output logic                  slot_req,
   output logic                  slot_rst,
   output logic                  slot_bit,
   output logic                  slot_spu,
   output logic                  busy,
   output logic                  done,
   output logic [W-1:0]          rx_byte,
   output logic                  presence_err
);
   localparam int IW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
   localparam logic [IW-1:0] ID_LAST = IW'(ID_BYTES - 1);

   seq_state_e            state_q;
   logic [IW-1:0]         idx_q;
   logic [W-1:0]          cmd_q;
   logic [ID_BYTES*W-1:0] id_q;
   logic                  use_id_q;
   logic                  spu_q;
   logic                  bit_state;
   logic                  fin;

   generate
      if (ID_BYTES < 1) begin : g_bad_id
         $error("owseq_ctrl: ID_BYTES must be at least 1");
      end
   endgenerate

   assign bit_state = (state_q == ST_ROM) || (state_q == ST_ID) ||
                      (state_q == ST_FUNC) || (state_q == ST_XFER);
   assign sh_step   = slot_ack && bit_state;
   assign fin       = sh_step && sh_last;

   assign slot_req  = (state_q != ST_IDLE);
   assign slot_rst  = (state_q == ST_RST);
   assign slot_bit  = bit_state && sh_bit;
   assign slot_spu  = (state_q == ST_FUNC) && spu_q && sh_last;
   assign busy      = slot_req;

   always_comb begin
      sh_load     = 1'b0;
      sh_load_val = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (start && (op != OP_CMD)) begin
               sh_load     = 1'b1;
               sh_load_val = op_is_read(op) ? {W{1'b1}} : tx_byte;
            end
         end
         ST_RST: begin
            if (slot_ack) begin
               sh_load     = 1'b1;
               sh_load_val = use_id_q ? CODE_SEL : CODE_ALL;
            end
         end
         ST_ROM: begin
            if (fin) begin
               sh_load     = 1'b1;
               sh_load_val = use_id_q ? id_q[0 +: W] : cmd_q;
            end
         end
         ST_ID: begin
            if (fin) begin
               sh_load     = 1'b1;
               sh_load_val = (idx_q == ID_LAST) ? cmd_q
                                                : id_q[(idx_q + 1'b1) * W +: W];
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         idx_q        <= '0;
         cmd_q        <= '0;
         id_q         <= '0;
         use_id_q     <= 1'b0;
         spu_q        <= 1'b0;
         done         <= 1'b0;
         rx_byte      <= '0;
         presence_err <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  cmd_q    <= cmd_byte;
                  id_q     <= dev_id;
                  use_id_q <= use_id;
                  spu_q    <= spu_opt && (op == OP_CMD);
                  idx_q    <= '0;
                  state_q  <= (op == OP_CMD) ? ST_RST : ST_XFER;
               end
            end
            ST_RST: begin
               if (slot_ack) begin
                  presence_err <= slot_nopres;
                  state_q      <= ST_ROM;
               end
            end
            ST_ROM: begin
               if (fin) begin
                  idx_q   <= '0;
                  state_q <= use_id_q ? ST_ID : ST_FUNC;
               end
            end
            ST_ID: begin
               if (fin) begin
                  if (idx_q == ID_LAST) state_q <= ST_FUNC;
                  else                  idx_q   <= idx_q + 1'b1;
               end
            end
            ST_FUNC, ST_XFER: begin
               if (fin) begin
                  rx_byte <= sh_next;
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R12: request fields hold until the engine acknowledges
   p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req && !slot_ack) |=> (slot_req && $stable(slot_rst) &&
                                   $stable(slot_bit) && $stable(slot_spu)));

   // R10: completion is a single-cycle pulse seen only when idle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R5 / R6: a command transfer opens with a reset slot
   p_reset_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (op == OP_CMD)) |=> (slot_req && slot_rst));

   // R7: a pullup request never rides on a reset slot
   p_spu_not_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      slot_spu |-> (slot_req && !slot_rst));

endmodule

// File: rtl/owseq_spu.sv
module owseq_spu (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic release_req,
   output logic on
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           on <= 1'b0;
      else if (arm)         on <= 1'b1;
      else if (release_req) on <= 1'b0;
   end
endmodule

// File: rtl/owseq_top.sv
module owseq_top #(
   parameter int          W        = 8,
   parameter int          ID_BYTES = 8,
   parameter bit          SPU_EN   = 1'b1,
   parameter logic [W-1:0] CODE_SEL = 8'h55,
   parameter logic [W-1:0] CODE_ALL = 8'hCC
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [1:0]            op,
   input  logic                  use_id,
   input  logic                  spu_opt,
   input  logic [W-1:0]          cmd_byte,
   input  logic [W-1:0]          tx_byte,
   input  logic [ID_BYTES*W-1:0] dev_id,
   output logic                  busy,
   output logic                  done,
   output logic [W-1:0]          rx_byte,
   output logic                  presence_err,
   output logic                  slot_req,
   output logic                  slot_rst,
   output logic                  slot_bit,
   output logic                  slot_spu,
   input  logic                  slot_ack,
   input  logic                  slot_rbit,
   input  logic                  slot_nopres,
   output logic                  spu_on,
   input  logic                  spu_release
);
   logic         sh_load;
   logic [W-1:0] sh_load_val;
   logic         sh_step;
   logic         sh_bit;
   logic         sh_last;
   logic [W-1:0] sh_next;
   logic         spu_raw;

   owseq_shift #(.W(W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (sh_load_val),
      .step     (sh_step),
      .rbit     (slot_rbit),
      .tx_bit   (sh_bit),
      .last     (sh_last),
      .next_val (sh_next)
   );

   owseq_ctrl #(
      .W        (W),
      .ID_BYTES (ID_BYTES),
      .CODE_SEL (CODE_SEL),
      .CODE_ALL (CODE_ALL)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .op           (op),
      .use_id       (use_id),
      .spu_opt      (spu_opt),
      .cmd_byte     (cmd_byte),
      .tx_byte      (tx_byte),
      .dev_id       (dev_id),
      .slot_ack     (slot_ack),
      .slot_nopres  (slot_nopres),
      .sh_last      (sh_last),
      .sh_next      (sh_next),
      .sh_bit       (sh_bit),
      .sh_load      (sh_load),
      .sh_load_val  (sh_load_val),
      .sh_step      (sh_step),
      .slot_req     (slot_req),
      .slot_rst     (slot_rst),
      .slot_bit     (slot_bit),
      .slot_spu     (spu_raw),
      .busy         (busy),
      .done         (done),
      .rx_byte      (rx_byte),
      .presence_err (presence_err)
   );

   generate
      if (SPU_EN) begin : g_spu
         assign slot_spu = spu_raw;
         owseq_spu u_spu (
            .clk         (clk),
            .rst_n       (rst_n),
            .arm         (slot_req && slot_ack && spu_raw),
            .release_req (spu_release),
            .on          (spu_on)
         );
      end else begin : g_no_spu
         logic unused_spu_in;
         assign unused_spu_in = spu_release ^ spu_raw;
         assign slot_spu      = 1'b0;
         assign spu_on        = 1'b0;
      end
   endgenerate

   // R8: the pullup turns on together with completion of the armed slot
   p_spu_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req && slot_ack && slot_spu) |=> (spu_on && done));

   // R8: once on, the pullup stays on until a release arrives
   p_spu_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (spu_on && !spu_release) |=> spu_on);

endmodule

// File: tb/owseq_top_bench.sv
module owseq_top_bench;
   localparam int W   = 8;
   localparam int IDB = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] op = 2'b00;
   logic use_id = 1'b0, spu_opt = 1'b0;
   logic [W-1:0] cmd_byte = '0, tx_byte = '0;
   logic [IDB*W-1:0] dev_id = '0;
   logic busy, done, presence_err, slot_req, slot_rst, slot_bit, slot_spu, spu_on;
   logic [W-1:0] rx_byte;
   logic slot_ack = 1'b0, slot_rbit = 1'b0, slot_nopres = 1'b0, spu_release = 1'b0;

   always #2 clk = ~clk;

   owseq_top u_owseq_top (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_id(use_id),
      .spu_opt(spu_opt), .cmd_byte(cmd_byte), .tx_byte(tx_byte), .dev_id(dev_id),
      .busy(busy), .done(done), .rx_byte(rx_byte), .presence_err(presence_err),
      .slot_req(slot_req), .slot_rst(slot_rst), .slot_bit(slot_bit),
      .slot_spu(slot_spu), .slot_ack(slot_ack), .slot_rbit(slot_rbit),
      .slot_nopres(slot_nopres), .spu_on(spu_on), .spu_release(spu_release));

   int n_cmp = 0, n_bad = 0;
   int cyc = 0;
   logic ended = 1'b0;

   logic lg_rst [0:127];
   logic lg_bit [0:127];
   logic lg_spu [0:127];
   logic lg_rb  [0:127];
   int   lg_n = 0;
   logic cfg_nopres = 1'b0;
   logic cfg_echo = 1'b0;

   logic ex_rst [0:127];
   logic ex_bit [0:127];
   logic ex_spu [0:127];
   int   ex_n = 0;

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         finish_run();
      end
   end

   // bit engine model
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && slot_req) begin
            int d = $urandom_range(1, 3);
            logic rb;
            if (lg_n < 128) begin
               lg_rst[lg_n] = slot_rst;
               lg_bit[lg_n] = slot_bit;
               lg_spu[lg_n] = slot_spu;
            end
            rb = slot_rst ? 1'b0 : (cfg_echo ? slot_bit : (slot_bit & 1'($urandom)));
            if (lg_n < 128) lg_rb[lg_n] = rb;
            lg_n++;
            repeat (d - 1) @(negedge clk);
            slot_ack = 1'b1;
            slot_rbit = rb;
            slot_nopres = cfg_nopres;
            @(negedge clk);
            slot_ack = 1'b0;
         end
      end
   end

   function automatic void push_rst();
      ex_rst[ex_n] = 1'b1; ex_bit[ex_n] = 1'b0; ex_spu[ex_n] = 1'b0; ex_n++;
   endfunction

   function automatic void push_byte(input logic [W-1:0] b, input logic spu_last);
      for (int k = 0; k < W; k++) begin
         ex_rst[ex_n] = 1'b0;
         ex_bit[ex_n] = b[k];
         ex_spu[ex_n] = spu_last && (k == W - 1);
         ex_n++;
      end
   endfunction

   task automatic run(input logic [1:0] o, input logic uid, input logic spu,
                      input logic [W-1:0] c, input logic [W-1:0] t,
                      input logic [IDB*W-1:0] id, input logic np, input logic poke,
                      input string tag);
      int wait_c = 0;
      logic seq_ok = 1'b1, spu_ok = 1'b1;
      logic [W-1:0] exp_rx;
      ex_n = 0;
      if (o == 2'b00) begin
         push_rst();
         push_byte(uid ? 8'h55 : 8'hCC, 1'b0);
         if (uid) for (int b = 0; b < IDB; b++) push_byte(id[b*W +: W], 1'b0);
         push_byte(c, spu);
      end else begin
         push_byte(o[1] ? 8'hFF : t, 1'b0);
      end
      cfg_nopres = np;
      op = o; use_id = uid; spu_opt = spu; cmd_byte = c; tx_byte = t; dev_id = id;
      lg_n = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R10", {tag, " busy after start"}, busy, 1);
      while (done !== 1'b1 && wait_c < 3000) begin
         @(negedge clk);
         wait_c++;
         if (poke && wait_c == 5) begin
            op = 2'b01; tx_byte = ~t; cmd_byte = ~c; dev_id = ~id; use_id = ~uid;
            start = 1'b1;
         end else if (poke && wait_c == 6) begin
            start = 1'b0;
         end
      end
      chk(done === 1'b1, "R10", {tag, " done seen"}, done, 1);
      chk(busy === 1'b0, "R10", {tag, " idle at done"}, busy, 0);
      for (int i = 0; i < ex_n; i++) begin
         if (i >= lg_n || lg_rst[i] !== ex_rst[i] || lg_bit[i] !== ex_bit[i]) seq_ok = 1'b0;
         if (i < lg_n && lg_spu[i] !== ex_spu[i]) spu_ok = 1'b0;
      end
      chk(seq_ok && lg_n == ex_n,
          (o == 2'b00) ? (uid ? (poke ? "R11" : "R5") : "R6") : (o[1] ? "R4" : "R2"),
          {tag, " slot count/sequence"}, lg_n, ex_n);
      chk(spu_ok, "R7", {tag, " pullup flag placement"}, spu_ok, 1);
      for (int k = 0; k < W; k++) exp_rx[k] = lg_rb[lg_n - W + k];
      chk(rx_byte === exp_rx, "R3", {tag, " received byte"}, rx_byte, exp_rx);
      if (o == 2'b00)
         chk(presence_err === np, "R9", {tag, " presence status"}, presence_err, np);
      if (o == 2'b00 && spu)
         chk(spu_on === 1'b1, "R8", {tag, " pullup on at done"}, spu_on, 1);
      @(negedge clk);
      chk(done === 1'b0, "R10", {tag, " done single pulse"}, done, 0);
   endtask

   task automatic release_spu(input string tag);
      repeat (3) @(negedge clk);
      chk(spu_on === 1'b1, "R8", {tag, " pullup held"}, spu_on, 1);
      spu_release = 1'b1;
      @(negedge clk);
      spu_release = 1'b0;
      chk(spu_on === 1'b0, "R8", {tag, " pullup released"}, spu_on, 0);
   endtask

   initial begin
      void'($urandom(32'd1979));
      repeat (3) @(negedge clk);
      chk(busy === 0 && done === 0 && spu_on === 0 && presence_err === 0 && slot_req === 0,
          "R1", "reset state", {busy, done, spu_on, presence_err, slot_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      run(2'b00, 1'b0, 1'b0, 8'h44, 8'h00, '0, 1'b0, 1'b0, "all-addr cmd");
      chk(spu_on === 1'b0, "R7", "no pullup without option", spu_on, 0);
      run(2'b00, 1'b1, 1'b1, 8'hBE, 8'h00, 64'h28FF_1234_5678_9A01, 1'b1, 1'b0, "select cmd spu");
      release_spu("select cmd spu");
      run(2'b10, 1'b0, 1'b0, 8'h00, 8'h00, '0, 1'b0, 1'b0, "read");
      cfg_echo = 1'b1;
      run(2'b11, 1'b0, 1'b0, 8'h00, 8'h00, '0, 1'b0, 1'b0, "read echo");
      chk(rx_byte === 8'hFF, "R4", "read echo returns all ones", rx_byte, 8'hFF);
      run(2'b01, 1'b0, 1'b0, 8'h00, 8'hA5, '0, 1'b0, 1'b0, "write echo");
      chk(rx_byte === 8'hA5, "R3", "write echo returns byte", rx_byte, 8'hA5);
      cfg_echo = 1'b0;
      run(2'b01, 1'b0, 1'b1, 8'h00, 8'h00, '0, 1'b0, 1'b0, "write zero spu ignored");
      chk(spu_on === 1'b0, "R7", "write never arms pullup", spu_on, 0);
      run(2'b00, 1'b1, 1'b0, 8'h48, 8'h00, 64'h0102_0304_0506_0708, 1'b0, 1'b1, "busy start");

      // constrained random
      for (int n = 0; n < 40; n++) begin
         logic [1:0] o = 2'($urandom);
         logic uid = 1'($urandom);
         logic sp = 1'($urandom);
         logic np = 1'($urandom);
         cfg_echo = 1'($urandom);
         run(o, uid, sp, 8'($urandom), 8'($urandom), {$urandom, $urandom}, np, 1'b0, "random");
         if (o == 2'b00 && sp) release_spu("random");
         else chk(spu_on === 1'b0, "R7", "random no pullup", spu_on, 0);
      end
      finish_run();
   end
endmodule